// File: doc/BRIEF.md
# Interleaved Serial-Load Column Drive Core

This block is the digital core of a multi-column display driver. Several 2-bit serial lanes (four by default) shift column codes in side by side while chip select is active. Each shift event fills one group of adjacent columns, one column per lane. A direction input mirrors the whole column mapping. When the active-low transfer strobe falls, the shift register is copied into a holding latch. Each latched code is then decoded into a per-column drive state.

Two global override inputs can force every column to ground, the medium level or the high level at once. A master enable floats every column. The shift clock, chip select and strobe are treated as plain samples in the system clock domain, and edges are found by comparing each sample with the previous one. The number of lanes and the number of stages per lane are parameters, with STAGES of at least 2. Columns are numbered from 0 in this block.

Top module: `coldrv_core`

## Requirements
- R1: After reset, every column reads OFF. The shift register and the latch are both zero, so a strobe given before any load still leaves every column OFF.
- R2: A rising edge on `sclk` shifts in one sample from all lanes only while `cs_n` is low. Edges on `sclk` while `cs_n` is high leave the shift register unchanged.
- R3: With `dir` high, STAGES samples are shifted in. Sample k (1-based) ends in columns LANES*(k-1)+i, where i is the lane number counted from 0.
- R4: With `dir` low, the mapping is mirrored. Sample k, lane i ends in column COLS-1-(LANES*(k-1)+i).
- R5: The latch takes the shift register contents on a falling edge of `ld_n`. Between such edges it holds its value, and shifting does not disturb the outputs.
- R6: In data-through mode, the code {first bit, second bit} of a column is decoded as follows. 00 gives OFF, 10 gives GND, 11 gives MID and 01 gives HIGH. A lane's first bit is `lane_dat[2i+1]` and its second bit is `lane_dat[2i]`. The drive state encoding on `drv[2c+1:2c]` is OFF=0, GND=1, MID=2, HIGH=3.
- R7: While `pwr_en` is low, every column is OFF, whatever the latch holds and whatever `ovr` is.
- R8: While `pwr_en` is high, `ovr` selects the mode as {`ovr[1]`,`ovr[0]`}. 00 means data-through, 10 forces every column to GND, 01 forces every column to MID and 11 forces every column to HIGH.
- R9: The override and the enable act on all columns combinationally, with no strobe needed. The latch keeps loading normally while an override is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Shift clock sample |
| cs_n | input | 1 | Active-low chip select |
| dir | input | 1 | Mapping direction (1: ascending, 0: mirrored) |
| lane_dat | input | 2*LANES | Lane codes, lane i on bits [2i+1:2i] |
| ld_n | input | 1 | Active-low transfer strobe |
| ovr | input | 2 | Global override select |
| pwr_en | input | 1 | Master output enable |
| drv | output | 2*LANES*STAGES | Per-column drive state, column c on bits [2c+1:2c] |

## Verification
An `sclk` or `ld_n` edge that is set up just after a clock edge is detected at the next clock edge, so the shift register or the latch has changed one cycle after the stimulus. Changes on `ovr` and `pwr_en` reach `drv` in the same cycle, with no register on the path. The driver applies its inputs 2 ns after a rising edge and queues the expected vector only after enough edges have passed. The monitor compares on the following falling edge, so every latched result is observed at least one full cycle after the strobe. Every override result is observed within the same cycle in which the override changed.

// File: rtl/coldrv_core.sv
module coldrv_core #(
  parameter int LANES  = 4,
  parameter int STAGES = 80,
  localparam int COLS  = LANES * STAGES,
  localparam int GW    = 2 * LANES,
  localparam int VW    = 2 * COLS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          dir,
  input  logic [GW-1:0] lane_dat,
  input  logic          ld_n,
  input  logic [1:0]    ovr,
  input  logic          pwr_en,
  output logic [VW-1:0] drv
);

  localparam logic [1:0] S_OFF = 2'd0, S_GND = 2'd1, S_MID = 2'd2, S_HIGH = 2'd3;

  logic          sclk_q, ld_q;
  logic [VW-1:0] sreg, hold;
  logic [GW-1:0] grp_rev;

  wire shift_ev = sclk & ~sclk_q & ~cs_n;
  wire load_ev  = ~ld_n & ld_q;

  for (genvar i = 0; i < LANES; i++) begin : g_rev
    assign grp_rev[2*(LANES-1-i) +: 2] = lane_dat[2*i +: 2];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      ld_q   <= 1'b1;
      sreg   <= '0;
      hold   <= '0;
    end else begin
      sclk_q <= sclk;
      ld_q   <= ld_n;
      if (shift_ev)
        sreg <= dir ? {lane_dat, sreg[VW-1:GW]} : {sreg[VW-GW-1:0], grp_rev};
      if (load_ev)
        hold <= sreg;
    end
  end

  logic [1:0] forced;
  always_comb begin
    unique case (ovr)
      2'b10:   forced = S_GND;
      2'b01:   forced = S_MID;
      2'b11:   forced = S_HIGH;
      default: forced = S_OFF;
    endcase
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [1:0] code, thru;
    assign code = hold[2*c +: 2];
    always_comb begin
      unique case (code)
        2'b10:   thru = S_GND;
        2'b11:   thru = S_MID;
        2'b01:   thru = S_HIGH;
        default: thru = S_OFF;
      endcase
    end
    assign drv[2*c +: 2] = !pwr_en ? S_OFF : (ovr == 2'b00) ? thru : forced;
  end

endmodule

// File: rtl/coldrv_chk.sv
module coldrv_chk #(
  parameter int LANES  = 4,
  parameter int STAGES = 80,
  localparam int VW    = 2 * LANES * STAGES
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_n,
  input logic [1:0]    ovr,
  input logic          pwr_en,
  input logic [VW-1:0] drv
);

  localparam int COLS = LANES * STAGES;

  p_all_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> drv == '0);

  p_force_gnd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && ovr == 2'b10) |-> drv == {COLS{2'd1}});

  p_force_mid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && ovr == 2'b01) |-> drv == {COLS{2'd2}});

  p_force_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && ovr == 2'b11) |-> drv == {COLS{2'd3}});

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ld_n) && pwr_en && ovr == 2'b00 && $past(pwr_en) && $past(ovr) == 2'b00)
      |-> $stable(drv));

endmodule

bind coldrv_core coldrv_chk #(.LANES(LANES), .STAGES(STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .ovr(ovr), .pwr_en(pwr_en), .drv(drv)
);

// File: tb/coldrv_core_tb.sv
module coldrv_core_tb;
  localparam int LANES  = 4;
  localparam int STAGES = 4;
  localparam int COLS   = LANES * STAGES;
  localparam int GW     = 2 * LANES;
  localparam int VW     = 2 * COLS;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, dir = 1'b1;
  logic ld_n = 1'b1, pwr_en = 1'b1;
  logic [GW-1:0] lane_dat = '0;
  logic [1:0]    ovr = 2'b00;
  logic [VW-1:0] drv;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  logic [1:0] pend [COLS];
  logic [1:0] shown [COLS];

  logic [VW-1:0] exp_q [$];
  string         tag_q [$];

  always #10 clk = ~clk;

  coldrv_core #(.LANES(LANES), .STAGES(STAGES)) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .dir(dir),
    .lane_dat(lane_dat), .ld_n(ld_n), .ovr(ovr), .pwr_en(pwr_en), .drv(drv)
  );

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [VW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_vec++;
      if (drv !== e) begin
        n_bad++;
        $display("FAIL %s: drv=%h expected=%h", t, drv, e);
      end
    end
  end

  function automatic logic [1:0] code_of(int seed, int k, int i);
    return 2'((seed + 3 * k + i + (k * i)) & 3);
  endfunction

  function automatic logic [1:0] dec(logic [1:0] c);
    case (c)
      2'b10: return 2'd1;
      2'b11: return 2'd2;
      2'b01: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [VW-1:0] model();
    logic [VW-1:0] v;
    for (int c = 0; c < COLS; c++) begin
      if (!pwr_en)            v[2*c +: 2] = 2'd0;
      else if (ovr == 2'b10)  v[2*c +: 2] = 2'd1;
      else if (ovr == 2'b01)  v[2*c +: 2] = 2'd2;
      else if (ovr == 2'b11)  v[2*c +: 2] = 2'd3;
      else                    v[2*c +: 2] = dec(shown[c]);
    end
    return v;
  endfunction

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic expect_vec(string tag);
    exp_q.push_back(model());
    tag_q.push_back(tag);
    @(negedge clk);
    #1;
  endtask

  task automatic load(int seed, logic d, logic sel_n);
    dir  = d;
    cs_n = sel_n;
    for (int k = 1; k <= STAGES; k++) begin
      for (int i = 0; i < LANES; i++) begin
        lane_dat[2*i +: 2] = code_of(seed, k, i);
        if (!sel_n) begin
          if (d) pend[LANES*(k-1)+i] = code_of(seed, k, i);
          else   pend[COLS-1-(LANES*(k-1)+i)] = code_of(seed, k, i);
        end
      end
      sclk = 1'b1; step();
      sclk = 1'b0; step();
    end
    cs_n = 1'b1;
    step();
  endtask

  task automatic strobe();
    ld_n = 1'b0; step();
    ld_n = 1'b1; step();
    for (int c = 0; c < COLS; c++) shown[c] = pend[c];
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < COLS; c++) begin pend[c] = 2'b00; shown[c] = 2'b00; end
    repeat (3) step();
    rst_n = 1'b1;
    step();
    expect_vec("R1 reset state");
    strobe();
    expect_vec("R1 strobe of cleared shift register");

    load(0, 1'b1, 1'b0);
    expect_vec("R5 outputs hold while shifting");
    strobe();
    expect_vec("R3 R6 ascending load");

    load(5, 1'b0, 1'b0);
    expect_vec("R5 hold after mirrored shift");
    strobe();
    expect_vec("R4 R6 mirrored load");

    load(2, 1'b1, 1'b1);
    strobe();
    expect_vec("R2 deselected edges ignored");

    load(9, 1'b1, 1'b0);
    strobe();
    expect_vec("R2 R3 second ascending pattern");
    strobe();
    expect_vec("R5 repeated strobe without shift");

    ovr = 2'b10; expect_vec("R8 force ground");
    ovr = 2'b01; expect_vec("R8 force medium");
    ovr = 2'b11; expect_vec("R9 force high same cycle");

    load(13, 1'b0, 1'b0);
    strobe();
    expect_vec("R9 override unaffected by strobe");
    ovr = 2'b00;
    expect_vec("R9 latch loaded during override");

    pwr_en = 1'b0; expect_vec("R7 disabled in data-through");
    ovr = 2'b11;   expect_vec("R7 disabled beats override");
    ovr = 2'b00; pwr_en = 1'b1;
    expect_vec("R7 enable restores data");

    step();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule